// File: doc/BRIEF.md
# DMA Channel Register File

This block is the host-facing programming interface of a four-channel DMA controller. A host issues byte-wide reads and writes over a 4-bit offset bus. For each channel the block holds a 16-bit base address and count, the current address and count, a 6-bit mode field and a mask bit. It also holds the controller-wide command, request, status and mask state. A transfer engine consumes the per-channel current address, count, mode and mask from the outputs. It reports each completed transfer back with a one-cycle step pulse per channel.

Each 16-bit quantity is reached through an 8-bit port. One byte-pointer flip-flop, shared by all address and count ports, picks which half is accessed. Offsets 0x8 to 0xF carry the controller-wide functions. The command port and the status port share an offset, and so do the master-clear port and the temporary port. Write strobe and read strobe must not be high in the same cycle; if both are, the write is taken. Read data is registered and appears one cycle after the read strobe.

Top module: `dma_chan_regs`

## Requirements
- R1: After a synchronous reset, all four masks are set, the byte pointer selects the low byte, and command, request, terminal-count flags, mode, address and count registers and `bus_rdata` are all zero.
- R2: Every read or write of an address or count port (offset 0x0 to 0x7) accesses the low byte when the byte pointer is clear and the high byte when it is set, then toggles the pointer. A write to offset 0xC forces the pointer back to low. Accesses to offsets 0x8 to 0xF do not toggle it.
- R3: Offset 2n is the address port of channel n and offset 2n+1 its count port. A byte write loads that byte into both the base and current copies. A read returns the addressed byte of the current copy on `bus_rdata` one cycle after `bus_rd`. `ch_addr` and `ch_count` show the current copies, channel n in bits [16n+15:16n].
- R4: A write to offset 0xB stores data bits 7:2 as the mode of the channel given by data bits 1:0, with `ch_mode` bits [6n+5:6n] = data[7:2]. Mode bit 3 (data bit 5) selects address decrement and mode bit 2 (data bit 4) selects auto-initialise. Bytes 0x44, 0x48 and 0xC0 store as 0x11, 0x12 and 0x30.
- R5: A write to offset 0xA sets (data bit 2 = 1) or clears (bit 2 = 0) the mask of the channel in data bits 1:0. A write to 0xE clears all masks. A write to 0xF loads all masks from data bits 3:0 (bit n = channel n).
- R6: A write to offset 0x8 loads `cmd_q`. A write to offset 0x9 sets (data bit 2 = 1) or clears the request bit of the channel in data bits 1:0, shown on `req_q`.
- R7: A read of offset 0x8 returns status: bits 3:0 are the terminal-count flags and bits 7:4 are `req_q` OR `dev_req`. The read clears the terminal-count flags, unless a terminal event occurs in the same cycle.
- R8: A write to offset 0xD sets all masks and clears the byte pointer, command, request and terminal-count flags. Channel address, count and mode registers are kept.
- R9: A step pulse on a channel decrements its current count and moves its current address by +1, or by -1 when mode bit 3 is set. When the step finds the count at zero, it sets that channel's terminal-count flag. It then either reloads both current copies from the base copies (auto-initialise set) or lets the count wrap to 0xFFFF. An address or count write to the same channel in the same cycle cancels the step.
- R10: Reads of offsets 0x9 to 0xF return 0x00; this includes the temporary port at 0xD. Such reads leave the byte pointer and all other state unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Host write strobe, one access per cycle |
| bus_rd | input | 1 | Host read strobe, one access per cycle |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Registered read data, valid the cycle after `bus_rd` |
| eng_step | input | 4 | One pulse per completed transfer, bit n for channel n |
| dev_req | input | 4 | Device request lines, reported in status |
| ch_addr | output | 64 | Current address of each channel |
| ch_count | output | 64 | Current count of each channel (transfers minus one) |
| ch_mode | output | 24 | Mode field of each channel |
| ch_mask | output | 4 | Mask bit of each channel |
| cmd_q | output | 8 | Command register |
| req_q | output | 4 | Software request bits |

## Verification
Directed sequences split the byte pointer's behaviours apart. A low/high write pair, a pair broken by a pointer clear, and a read interleaved with a write-only-port read each give a different value if the pointer toggles wrongly or not at all. Steps are applied at a count of zero with and without auto-initialise, and with increment and with decrement. These show the wrap to 0xFFFF, the reload from the base copies and the direction of address movement. Status is read twice after a terminal event to show the read-clear. Random mixes of port writes, reads, mode and mask writes, controller commands and steps run against a bench model, which compares every output after each operation.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
  localparam int MODE_W = 6;

  localparam logic [3:0] OFS_CMD     = 4'h8;
  localparam logic [3:0] OFS_REQ     = 4'h9;
  localparam logic [3:0] OFS_SMASK   = 4'hA;
  localparam logic [3:0] OFS_MODE    = 4'hB;
  localparam logic [3:0] OFS_CLRPTR  = 4'hC;
  localparam logic [3:0] OFS_MCLR    = 4'hD;
  localparam logic [3:0] OFS_CLRMASK = 4'hE;
  localparam logic [3:0] OFS_ALLMASK = 4'hF;

  // stored mode field: data byte bits 7:2
  typedef struct packed {
    logic [1:0] kind;   // data[7:6]: transfer kind (single/block/cascade)
    logic       dec;    // data[5]: address decrement
    logic       auto;   // data[4]: auto-initialise
    logic [1:0] dir;    // data[3:2]: transfer direction
  } mode_t;
endpackage

// File: rtl/dma_byte_ptr.sv
module dma_byte_ptr (
  input  logic clk,
  input  logic rst,
  input  logic acc,
  input  logic clr,
  output logic hi
);
  always_ff @(posedge clk) begin
    if (rst || clr) hi <= 1'b0;
    else if (acc)   hi <= ~hi;
  end

  assert_ptr_toggle_R2: assert property (@(posedge clk) disable iff (rst)
    (acc && !clr) |=> (hi != $past(hi)));
  assert_ptr_clear_R2: assert property (@(posedge clk) disable iff (rst)
    clr |=> !hi);
endmodule

// File: rtl/dma_chan_slice.sv
module dma_chan_slice import dma_regs_pkg::*; #(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_addr,
  input  logic              wr_cnt,
  input  logic              hi,
  input  logic [DW-1:0]     wdata,
  input  logic              mode_wr,
  input  logic [MODE_W-1:0] mode_data,
  input  logic              step,
  output logic [2*DW-1:0]   cur_addr,
  output logic [2*DW-1:0]   cur_cnt,
  output logic [MODE_W-1:0] mode,
  output logic              tc_evt
);
  localparam int W = 2*DW;

  logic [W-1:0] base_addr, base_cnt;
  mode_t        mode_q;
  logic         any_wr, step_ok, at_zero;

  assign any_wr  = wr_addr | wr_cnt;
  assign step_ok = step & ~any_wr;
  assign at_zero = (cur_cnt == '0);
  assign tc_evt  = step_ok & at_zero;
  assign mode    = mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_addr <= '0;
      cur_addr  <= '0;
    end else if (wr_addr) begin
      if (hi) begin
        base_addr[W-1:DW] <= wdata;
        cur_addr[W-1:DW]  <= wdata;
      end else begin
        base_addr[DW-1:0] <= wdata;
        cur_addr[DW-1:0]  <= wdata;
      end
    end else if (step_ok && !wr_cnt) begin
      if (at_zero && mode_q.auto) cur_addr <= base_addr;
      else if (mode_q.dec)        cur_addr <= cur_addr - 1'b1;
      else                        cur_addr <= cur_addr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_cnt <= '0;
      cur_cnt  <= '0;
    end else if (wr_cnt) begin
      if (hi) begin
        base_cnt[W-1:DW] <= wdata;
        cur_cnt[W-1:DW]  <= wdata;
      end else begin
        base_cnt[DW-1:0] <= wdata;
        cur_cnt[DW-1:0]  <= wdata;
      end
    end else if (step_ok && !wr_addr) begin
      if (at_zero && mode_q.auto) cur_cnt <= base_cnt;
      else                        cur_cnt <= cur_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          mode_q <= '0;
    else if (mode_wr) mode_q <= mode_t'(mode_data);
  end

  assert_base_cur_addr_R3: assert property (@(posedge clk) disable iff (rst)
    wr_addr |=> (base_addr == cur_addr) || $past(base_addr != cur_addr));
  assert_wrap_R9: assert property (@(posedge clk) disable iff (rst)
    (tc_evt && !mode_q.auto) |=> (cur_cnt == {W{1'b1}}));
  assert_reload_R9: assert property (@(posedge clk) disable iff (rst)
    (tc_evt && mode_q.auto) |=> (cur_cnt == base_cnt) && (cur_addr == base_addr));
endmodule

// File: rtl/dma_ctrl_regs.sv
module dma_ctrl_regs import dma_regs_pkg::*; #(
  parameter int NCH = 4,
  parameter int DW  = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr,
  input  logic           rd,
  input  logic [3:0]     addr,
  input  logic [DW-1:0]  wdata,
  input  logic [NCH-1:0] tc_evt,
  input  logic [NCH-1:0] dev_req,
  output logic [NCH-1:0] mask,
  output logic [DW-1:0]  cmd,
  output logic [NCH-1:0] req,
  output logic [DW-1:0]  status
);
  localparam int CHW = $clog2(NCH);

  logic [NCH-1:0] tc;
  logic [CHW-1:0] wch;
  logic           mclr, stat_rd;

  assign wch     = wdata[CHW-1:0];
  assign mclr    = wr && (addr == OFS_MCLR);
  assign stat_rd = rd && (addr == OFS_CMD);

  always_comb begin
    status = '0;
    status[NCH-1:0]     = tc;
    status[2*NCH-1:NCH] = req | dev_req;
  end

  always_ff @(posedge clk) begin
    if (rst || mclr)                         mask <= '1;
    else if (wr && addr == OFS_CLRMASK)      mask <= '0;
    else if (wr && addr == OFS_ALLMASK)      mask <= wdata[NCH-1:0];
    else if (wr && addr == OFS_SMASK)        mask[wch] <= wdata[2];
  end

  always_ff @(posedge clk) begin
    if (rst || mclr)                 cmd <= '0;
    else if (wr && addr == OFS_CMD)  cmd <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || mclr)                 req <= '0;
    else if (wr && addr == OFS_REQ)  req[wch] <= wdata[2];
  end

  always_ff @(posedge clk) begin
    if (rst || mclr) tc <= '0;
    else             tc <= (stat_rd ? '0 : tc) | tc_evt;
  end

  assert_mclr_R8: assert property (@(posedge clk) disable iff (rst)
    mclr |=> (mask == '1) && (cmd == '0) && (req == '0) && (tc == '0));
  assert_smask_R5: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == OFS_SMASK) |=> (((mask >> $past(wch)) & 1'b1) == NCH'($past(wdata[2]))));
  assert_stat_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && tc_evt == '0) |=> (tc == '0));
  assert_tc_set_R9: assert property (@(posedge clk) disable iff (rst)
    (tc_evt != '0) |=> ((tc & $past(tc_evt)) == $past(tc_evt)));
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs import dma_regs_pkg::*; #(
  parameter int NCH = 4,
  parameter int DW  = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [3:0]          bus_addr,
  input  logic [DW-1:0]       bus_wdata,
  output logic [DW-1:0]       bus_rdata,
  input  logic [NCH-1:0]      eng_step,
  input  logic [NCH-1:0]      dev_req,
  output logic [NCH*2*DW-1:0] ch_addr,
  output logic [NCH*2*DW-1:0] ch_count,
  output logic [NCH*MODE_W-1:0] ch_mode,
  output logic [NCH-1:0]      ch_mask,
  output logic [DW-1:0]       cmd_q,
  output logic [NCH-1:0]      req_q
);
  localparam int W   = 2*DW;
  localparam int CHW = $clog2(NCH);
  localparam logic [3:0] CH_PORTS = 4'(2*NCH);

  logic           rd_en, chan_hit, chan_acc, ptr_clr, ptr_hi, is_cnt;
  logic [CHW-1:0] ch_idx;
  logic [NCH-1:0] tc_evt;
  logic [DW-1:0]  status, rd_mux;
  logic [W-1:0]   rd_word;

  assign rd_en    = bus_rd & ~bus_wr;
  assign chan_hit = (bus_addr < CH_PORTS);
  assign chan_acc = (bus_wr | rd_en) & chan_hit;
  assign ptr_clr  = bus_wr && (bus_addr == OFS_CLRPTR || bus_addr == OFS_MCLR);
  assign ch_idx   = bus_addr[CHW:1];
  assign is_cnt   = bus_addr[0];

  dma_byte_ptr u_ptr (
    .clk (clk), .rst (rst), .acc (chan_acc), .clr (ptr_clr), .hi (ptr_hi)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic sel, mode_wr;
    assign sel     = chan_hit && (ch_idx == CHW'(g));
    assign mode_wr = bus_wr && (bus_addr == OFS_MODE) && (bus_wdata[CHW-1:0] == CHW'(g));
    dma_chan_slice #(.DW(DW)) u_slice (
      .clk       (clk),
      .rst       (rst),
      .wr_addr   (bus_wr & sel & ~is_cnt),
      .wr_cnt    (bus_wr & sel & is_cnt),
      .hi        (ptr_hi),
      .wdata     (bus_wdata),
      .mode_wr   (mode_wr),
      .mode_data (bus_wdata[MODE_W+1:2]),
      .step      (eng_step[g]),
      .cur_addr  (ch_addr[g*W +: W]),
      .cur_cnt   (ch_count[g*W +: W]),
      .mode      (ch_mode[g*MODE_W +: MODE_W]),
      .tc_evt    (tc_evt[g])
    );
  end

  dma_ctrl_regs #(.NCH(NCH), .DW(DW)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wr      (bus_wr),
    .rd      (rd_en),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .tc_evt  (tc_evt),
    .dev_req (dev_req),
    .mask    (ch_mask),
    .cmd     (cmd_q),
    .req     (req_q),
    .status  (status)
  );

  always_comb begin
    rd_word = is_cnt ? ch_count[ch_idx*W +: W] : ch_addr[ch_idx*W +: W];
    if (chan_hit)                rd_mux = ptr_hi ? rd_word[W-1:DW] : rd_word[DW-1:0];
    else if (bus_addr == OFS_CMD) rd_mux = status;
    else                         rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)        bus_rdata <= '0;
    else if (rd_en) bus_rdata <= rd_mux;
  end

  assert_mode_store_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFS_MODE) |=>
      (MODE_W'(ch_mode >> ($past(bus_wdata[CHW-1:0]) * MODE_W)) == $past(bus_wdata[MODE_W+1:2])));
  assert_quiet_read_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_en && bus_addr > OFS_CMD) |=> (bus_rdata == '0));
  assert_cmd_load_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFS_CMD) |=> (cmd_q == $past(bus_wdata)));
endmodule

// File: tb/tb_dma_chan_regs.sv
module tb_dma_chan_regs;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst, bus_wr, bus_rd;
  logic [3:0]  bus_addr;
  logic [7:0]  bus_wdata, bus_rdata;
  logic [3:0]  eng_step, dev_req;
  logic [63:0] ch_addr, ch_count;
  logic [23:0] ch_mode;
  logic [3:0]  ch_mask, req_q;
  logic [7:0]  cmd_q;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_regs dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_step(eng_step), .dev_req(dev_req),
    .ch_addr(ch_addr), .ch_count(ch_count), .ch_mode(ch_mode), .ch_mask(ch_mask),
    .cmd_q(cmd_q), .req_q(req_q)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  logic [15:0] mba [4], mca [4], mbc [4], mcc [4];
  logic [5:0]  mmode [4];
  logic [3:0]  mmask, mreq, mtc;
  logic [7:0]  mcmd;
  logic        mptr;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin
      mba[i] = 0; mca[i] = 0; mbc[i] = 0; mcc[i] = 0; mmode[i] = 0;
    end
    mmask = 4'hF; mreq = 0; mtc = 0; mcmd = 0; mptr = 0;
  endtask

  task automatic do_wr(input logic [3:0] a, input logic [7:0] d);
    int ch;
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
    ch = int'(a[2:1]);
    if (a < 4'h8) begin
      if (a[0]) begin
        if (mptr) begin mbc[ch][15:8] = d; mcc[ch][15:8] = d; end
        else      begin mbc[ch][7:0]  = d; mcc[ch][7:0]  = d; end
      end else begin
        if (mptr) begin mba[ch][15:8] = d; mca[ch][15:8] = d; end
        else      begin mba[ch][7:0]  = d; mca[ch][7:0]  = d; end
      end
      mptr = ~mptr;
    end else begin
      case (a)
        4'h8: mcmd = d;
        4'h9: mreq[d[1:0]] = d[2];
        4'hA: mmask[d[1:0]] = d[2];
        4'hB: mmode[d[1:0]] = d[7:2];
        4'hC: mptr = 0;
        4'hD: begin mmask = 4'hF; mptr = 0; mcmd = 0; mreq = 0; mtc = 0; end
        4'hE: mmask = 0;
        default: mmask = d[3:0];
      endcase
    end
  endtask

  task automatic do_rd(input logic [3:0] a, input string tag);
    logic [7:0]  exp;
    logic [15:0] w;
    int ch;
    ch = int'(a[2:1]);
    if (a < 4'h8) begin
      w = a[0] ? mcc[ch] : mca[ch];
      exp = mptr ? w[15:8] : w[7:0];
      mptr = ~mptr;
    end else if (a == 4'h8) begin
      exp = {mreq | dev_req, mtc};
      mtc = 0;
    end else exp = 8'h00;
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    chk(tag, 32'(bus_rdata), 32'(exp));
  endtask

  task automatic do_step(input int ch);
    @(negedge clk);
    eng_step = 4'(1 << ch);
    @(negedge clk);
    eng_step = 0;
    if (mcc[ch] == 0) begin
      mtc[ch] = 1;
      if (mmode[ch][2]) begin mca[ch] = mba[ch]; mcc[ch] = mbc[ch]; end
      else begin
        mcc[ch] = 16'hFFFF;
        mca[ch] = mmode[ch][3] ? mca[ch] - 1 : mca[ch] + 1;
      end
    end else begin
      mcc[ch] = mcc[ch] - 1;
      mca[ch] = mmode[ch][3] ? mca[ch] - 1 : mca[ch] + 1;
    end
  endtask

  task automatic chk_outs();
    for (int i = 0; i < 4; i++) begin
      chk("R3 ch_addr", 32'(ch_addr[i*16 +: 16]), 32'(mca[i]));
      chk("R9 ch_count", 32'(ch_count[i*16 +: 16]), 32'(mcc[i]));
      chk("R4 ch_mode", 32'(ch_mode[i*6 +: 6]), 32'(mmode[i]));
    end
    chk("R5 ch_mask", 32'(ch_mask), 32'(mmask));
    chk("R6 cmd_q", 32'(cmd_q), 32'(mcmd));
    chk("R6 req_q", 32'(req_q), 32'(mreq));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int unsigned r;
    r = $urandom(32'd20240611);
    rst = 1; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0; eng_step = 0; dev_req = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 rdata", 32'(bus_rdata), 0);
    chk("R1 mask", 32'(ch_mask), 32'hF);
    chk_outs();

    // R2 R3 low then high, read back current
    do_wr(4'h2, 8'h34); do_wr(4'h2, 8'h12);
    chk("R3 ch1 addr", 32'(ch_addr[31:16]), 32'h1234);
    do_rd(4'h2, "R3 read low"); do_rd(4'h2, "R3 read high");
    // R2 pointer clear between bytes
    do_wr(4'h5, 8'h56); do_wr(4'hC, 8'h00); do_wr(4'h5, 8'h78);
    chk("R2 clear ptr", 32'(ch_count[47:32]), 32'h0078);
    do_wr(4'h5, 8'h00);
    // R4 mode bytes
    do_wr(4'hB, 8'h44 | 8'h1); chk("R4 0x44", 32'(ch_mode[11:6]), 32'h11);
    do_wr(4'hB, 8'h48 | 8'h2); chk("R4 0x48", 32'(ch_mode[17:12]), 32'h12);
    do_wr(4'hB, 8'hC0 | 8'h3); chk("R4 0xC0", 32'(ch_mode[23:18]), 32'h30);
    // R9 terminal without auto-init
    do_wr(4'h3, 8'h00); do_wr(4'h3, 8'h00);
    do_step(1);
    chk("R9 wrap", 32'(ch_count[31:16]), 32'hFFFF);
    chk("R9 addr inc", 32'(ch_addr[31:16]), 32'h1235);
    do_rd(4'h8, "R7 status tc");
    do_rd(4'h8, "R7 status cleared");
    // R9 auto-init reload
    do_wr(4'hB, 8'h54);
    do_wr(4'h0, 8'h00); do_wr(4'h0, 8'h01); do_wr(4'h1, 8'h01); do_wr(4'h1, 8'h00);
    do_step(0); do_step(0);
    chk("R9 reload cnt", 32'(ch_count[15:0]), 32'h0001);
    chk("R9 reload addr", 32'(ch_addr[15:0]), 32'h0100);
    // R9 decrement
    do_wr(4'hB, 8'h66);
    do_step(2);
    chk("R9 dec", 32'(ch_addr[47:32]), 32'hFFFF);
    // R5 masks
    do_wr(4'hA, 8'h01); chk("R5 unmask", 32'(ch_mask), 32'hD);
    do_wr(4'hE, 8'h00); chk("R5 clear all", 32'(ch_mask), 32'h0);
    do_wr(4'hF, 8'h05); chk("R5 write all", 32'(ch_mask), 32'h5);
    // R6 R7 request and device request
    do_wr(4'h9, 8'h06); chk("R6 req", 32'(req_q), 32'h4);
    dev_req = 4'h1;
    do_rd(4'h8, "R7 pending");
    dev_req = 0;
    // R10 write-only reads leave pointer
    do_wr(4'h6, 8'hAB);
    do_rd(4'hB, "R10 mode read");
    do_rd(4'hD, "R10 temp read");
    do_wr(4'h6, 8'hCD);
    chk("R10 ptr kept", 32'(ch_addr[63:48]), 32'hCDAB);
    // R8 master clear
    do_wr(4'h8, 8'h5A); do_wr(4'h6, 8'h11);
    do_wr(4'hD, 8'h00);
    chk("R8 mask", 32'(ch_mask), 32'hF);
    chk("R8 cmd", 32'(cmd_q), 0);
    do_wr(4'h6, 8'h22);
    chk("R8 ptr low, addr kept", 32'(ch_addr[63:48]), 32'hCD22);
    chk_outs();

    // random mix
    for (int it = 0; it < 400; it++) begin
      r = $urandom % 8;
      case (r)
        0, 1: do_wr(4'($urandom % 8), 8'($urandom));
        2:    do_rd(4'($urandom % 8), "R3 rand read");
        3:    do_wr(4'hB, 8'($urandom));
        4:    do_wr(4'(8 + $urandom % 8), 8'($urandom));
        5:    do_rd(4'(8 + $urandom % 8), "R7 rand ctrl read");
        6:    do_step(int'($urandom % 4));
        default: dev_req = 4'($urandom);
      endcase
      chk_outs();
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule